// File: doc/BRIEF.md
# Byte-Wide SPI Controller with Master and Slave Modes

This block is a byte-oriented serial peripheral interface for an 8-bit microcontroller register bus. Software sees three registers: a control register that sets the mode, a status register carrying two event flags, and a data register. In master mode the block makes its own serial clock from the system clock. In slave mode it follows a clock and an active-low select driven from outside. All four clock polarity and phase combinations are supported, and bits can go out most-significant or least-significant first.

In master mode, a data-register write while idle sends that byte and receives a byte in its place, in the same register. Each finished byte raises a completion flag, which can request an interrupt. A data-register write made while a byte is in flight is dropped and raises a collision flag. Both flags are cleared by a two-step sequence: a status read that sees a flag set, followed by any access to the data register. In slave mode the external clock, select and data-in pins pass through two-flop synchronizers. The shifter then advances on the detected clock edges, so the whole block runs on the system clock.

Top module: `spi_port_ctrl`

## Requirements
- R1: After reset the control register reads 8'h04, the status register reads 8'h00, irq is 0, sck_o is 0 and miso_oe is 0.
- R2: The register address selects control at 2'd0, status at 2'd1 and data at 2'd2. Control bits 7..0 are interrupt enable, block enable, order, master, polarity, phase, rate[1] and rate[0]. In status, bit 7 is the completion flag, bit 6 is the collision flag, and bits 5..0 read 0.
- R3: With enable=1 and master=1, a data write while idle starts an 8-bit transfer. The written byte is sent on mosi_o, and afterwards a data read returns the byte taken from miso_i.
- R4: In master mode, sck_o toggles every 2, 8, 32 or 64 system clocks for rate codes 0, 1, 2 and 3, giving SCK at clock/4, /16, /64 and /128.
- R5: When not transferring, sck_o rests at the polarity bit. With phase=0, data is sampled on the leading SCK edge and changed on the trailing edge. With phase=1, data is changed on the leading edge and sampled on the trailing edge.
- R6: Order=1 sends and receives bit 0 first. Order=0 sends and receives bit 7 first.
- R7: A data write during a transfer sets the collision flag and is discarded: the transfer and the received byte are unaffected.
- R8: A status read that sees a flag set, followed by a data read or write, clears both flags. A data access with no such status read before it, or a status read alone, leaves the flags set.
- R9: irq is 1 exactly when the completion flag, the interrupt-enable bit and glb_irq_en are all 1.
- R10: In slave mode (enable=1, master=0), the shifter runs only while ss_n_i is low, and miso_oe is 1 only then. The byte exchanged with an external master ends up in the data register and on miso_o. The rate bits have no effect.
- R11: The completion flag is set at the end of each 8-bit transfer, in both master and slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational from reg_addr) |
| glb_irq_en | input | 1 | System-level serial interrupt enable |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock driven in master mode |
| mosi_o | output | 1 | Serial data out in master mode |
| miso_i | input | 1 | Serial data in for master mode |
| sck_i | input | 1 | Serial clock from an external master |
| ss_n_i | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_o | output | 1 | Serial data out in slave mode |
| miso_oe | output | 1 | Output enable for miso_o |

## Verification
The bench plays the far side of the link in every polarity, phase and bit-order combination. A wrong phase or order shows up as bit-reversed or one-bit-shifted bytes in the scoreboard. It times the SCK half-period for each rate code, so a divider that is off by one or by a factor of two is caught. A mid-transfer write must leave the received byte intact, which catches a design that reloads the shifter on collision. The flag clear is probed in both wrong orders, which catches a design that clears on a status read alone or on any data access. In slave mode the bench toggles the clock while the block is deselected, to catch a shifter that does not wait for the select.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int BYTE_W = 8;
  localparam int RATE_CNT_W = 7;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam logic [BYTE_W-1:0] CTRL_RST = 8'h04;

  typedef struct packed {
    logic       irq_en;
    logic       enable;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  // System clocks per SCK half-period for each rate code
  function automatic int half_period(input logic [1:0] code);
    case (code)
      2'd0:    half_period = 2;
      2'd1:    half_period = 8;
      2'd2:    half_period = 32;
      default: half_period = 64;
    endcase
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_port_pkg::*;
#(
  parameter int CNT_W = RATE_CNT_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d, limit;

  always_comb begin
    limit = CNT_W'(half_period(rate) - 1);
    tick  = run && (cnt_q == limit);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              edge_ev,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              din,
  output logic [DATA_W-1:0] data,
  output logic              dout,
  output logic              active,
  output logic              done
);
  localparam int EDGES  = 2 * DATA_W;
  localparam int EDGE_W = $clog2(EDGES);

  logic [EDGE_W-1:0] ecnt_q, ecnt_d;
  logic              hold_q, hold_d;
  logic [DATA_W-1:0] sr_q, sr_d;
  logic              lead, last, do_sample, do_shift;

  function automatic logic [DATA_W-1:0] push_bit(input logic [DATA_W-1:0] v,
                                                 input logic b, input logic lsb);
    if (lsb) push_bit = {b, v[DATA_W-1:1]};
    else     push_bit = {v[DATA_W-2:0], b};
  endfunction

  always_comb begin
    lead      = ~ecnt_q[0];
    last      = (ecnt_q == EDGE_W'(EDGES - 1));
    do_sample = cpha ? ~lead : lead;
    do_shift  = cpha ? (lead && (ecnt_q != '0)) : ~lead;
    ecnt_d    = ecnt_q;
    hold_d    = hold_q;
    sr_d      = sr_q;
    if (!run) begin
      ecnt_d = '0;
    end else if (edge_ev) begin
      ecnt_d = last ? '0 : ecnt_q + 1'b1;
      if (do_sample) hold_d = din;
      if (do_shift)  sr_d = push_bit(sr_q, hold_q, lsb_first);
      if (cpha && last) sr_d = push_bit(sr_q, din, lsb_first);
    end
    if (load) sr_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt_q <= '0;
      hold_q <= 1'b0;
    end else begin
      ecnt_q <= ecnt_d;
      hold_q <= hold_d;
    end
  end

  // Data register keeps its contents through reset
  always_ff @(posedge clk) sr_q <= sr_d;

  assign data   = sr_q;
  assign dout   = lsb_first ? sr_q[0] : sr_q[DATA_W-1];
  assign active = (ecnt_q != '0);
  assign done   = run && edge_ev && last;
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              glb_irq_en,
  output logic              irq,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  input  logic              sck_i,
  input  logic              ss_n_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe
);
  ctrl_t ctrl_q, ctrl_d;
  logic  spif_q, spif_d, wcol_q, wcol_d, armed_q, armed_d;
  logic  m_busy_q, m_busy_d, m_phase_q, m_phase_d;
  logic  sck_prev_q;
  logic  sck_s, ss_n_s, mosi_s;
  logic  m_tick, master_mode, slave_sel, run, edge_ev, din, busy, start;
  logic  data_wr, data_acc, stat_rd, ctrl_wr;
  logic  core_active, xfer_done, sdout;
  logic [BYTE_W-1:0] sr_data;

  spi_in_sync #(.N(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sck_i, ss_n_i, mosi_i}),
    .q({sck_s, ss_n_s, mosi_s})
  );

  spi_rate_gen u_rate (
    .clk(clk), .rst_n(rst_n), .run(m_busy_q), .rate(ctrl_q.rate), .tick(m_tick)
  );

  always_comb begin
    master_mode = ctrl_q.enable && ctrl_q.master;
    slave_sel   = ctrl_q.enable && !ctrl_q.master && !ss_n_s;
    run         = master_mode ? m_busy_q : slave_sel;
    edge_ev     = master_mode ? m_tick : (slave_sel && (sck_s != sck_prev_q));
    din         = master_mode ? miso_i : mosi_s;
    busy        = master_mode ? m_busy_q : (slave_sel && core_active);
    data_wr     = reg_wr && (reg_addr == ADDR_DATA);
    data_acc    = (reg_wr || reg_rd) && (reg_addr == ADDR_DATA);
    stat_rd     = reg_rd && (reg_addr == ADDR_STAT);
    ctrl_wr     = reg_wr && (reg_addr == ADDR_CTRL);
    start       = data_wr && !busy && master_mode;
  end

  spi_shift_core #(.DATA_W(BYTE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run(run), .load(data_wr && !busy),
    .load_val(reg_wdata), .edge_ev(edge_ev), .cpha(ctrl_q.cpha),
    .lsb_first(ctrl_q.lsb_first), .din(din), .data(sr_data), .dout(sdout),
    .active(core_active), .done(xfer_done)
  );

  // Next state: control, master sequencing, flags
  always_comb begin
    ctrl_d    = ctrl_wr ? ctrl_t'(reg_wdata) : ctrl_q;
    m_busy_d  = m_busy_q;
    if (!master_mode)   m_busy_d = 1'b0;
    else if (start)     m_busy_d = 1'b1;
    else if (xfer_done) m_busy_d = 1'b0;
    if (!m_busy_q)   m_phase_d = 1'b0;
    else if (m_tick) m_phase_d = ~m_phase_q;
    else             m_phase_d = m_phase_q;

    spif_d  = spif_q;
    wcol_d  = wcol_q;
    armed_d = armed_q;
    if (stat_rd && (spif_q || wcol_q)) armed_d = 1'b1;
    if (data_acc && armed_q) begin
      spif_d  = 1'b0;
      wcol_d  = 1'b0;
      armed_d = 1'b0;
    end
    if (data_wr && busy) wcol_d = 1'b1;
    if (xfer_done)       spif_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= ctrl_t'(CTRL_RST);
      m_busy_q   <= 1'b0;
      m_phase_q  <= 1'b0;
      spif_q     <= 1'b0;
      wcol_q     <= 1'b0;
      armed_q    <= 1'b0;
      sck_prev_q <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      m_busy_q   <= m_busy_d;
      m_phase_q  <= m_phase_d;
      spif_q     <= spif_d;
      wcol_q     <= wcol_d;
      armed_q    <= armed_d;
      sck_prev_q <= sck_s;
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = ctrl_q;
      ADDR_STAT: reg_rdata = {spif_q, wcol_q, 6'b0};
      ADDR_DATA: reg_rdata = sr_data;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq     = spif_q && ctrl_q.irq_en && glb_irq_en;
  assign sck_o   = ctrl_q.cpol ^ m_phase_q;
  assign mosi_o  = sdout;
  assign miso_o  = sdout;
  assign miso_oe = slave_sel;

  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !m_busy_q |-> (sck_o == ctrl_q.cpol));                               // R5
  AST_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy) |=> wcol_q);                                        // R7
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spif_q) |-> $past(busy));                                       // R11
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && data_acc && !xfer_done && !(data_wr && busy))
      |=> (!spif_q && !wcol_q));                                          // R8
  AST_MASTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !busy && master_mode) |=> m_busy_q);                      // R3
endmodule

// File: tb/test_spi_port_ctrl.sv
module test_spi_port_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic [1:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic       glb_irq_en, irq, sck_o, mosi_o, miso_i, sck_i, ss_n_i, mosi_i;
  logic       miso_o, miso_oe;

  int n_chk = 0, n_fail = 0, cyc = 0, tog_n = 0;
  int tog_t [2];
  logic mosi_q;
  logic [7:0] got_byte;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  event       model_done;

  spi_port_ctrl i_spi_port_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .glb_irq_en(glb_irq_en), .irq(irq), .sck_o(sck_o), .mosi_o(mosi_o),
    .miso_i(miso_i), .sck_i(sck_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_oe(miso_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) begin cyc <= cyc + 1; mosi_q <= mosi_o; end
  always @(sck_o) begin
    if (tog_n < 2) tog_t[tog_n] = cyc;
    tog_n++;
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int bp(input int i, input bit lsb);
    return lsb ? i : 7 - i;
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  // Scoreboard monitor: pops expected serial bytes as the far side reports them
  initial forever begin
    @(model_done);
    if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
    else check(tag_q.pop_front(), got_byte, exp_q.pop_front());
  end

  // Far-side slave for master-mode tests
  task automatic far_slave(input logic [7:0] tx, input bit cpha, input bit lsb);
    logic [7:0] rx = '0;
    if (!cpha) miso_i = tx[bp(0, lsb)];
    for (int i = 0; i < 8; i++) begin
      @(sck_o);
      if (cpha) miso_i = tx[bp(i, lsb)]; else rx[bp(i, lsb)] = mosi_q;
      @(sck_o);
      if (cpha) rx[bp(i, lsb)] = mosi_q; else if (i < 7) miso_i = tx[bp(i+1, lsb)];
    end
    got_byte = rx;
    -> model_done;
  endtask

  task automatic clear_flags(input logic [7:0] stat_exp, input logic [7:0] data_exp);
    logic [7:0] v;
    bus_read(2'd2, v);  check("R3 received byte (R7 discard)", v, data_exp);
    bus_read(2'd1, v);  check("R8 flags kept after data access alone", v, stat_exp);
    bus_read(2'd1, v);  check("R8 flags kept after status read alone", v, stat_exp);
    bus_read(2'd2, v);
    bus_read(2'd1, v);  check("R8 flags cleared by status then data", v, 8'h00);
  endtask

  task automatic master_xfer(input logic [7:0] cfg, input logic [7:0] tx,
                             input logic [7:0] stx, input int half, input bit collide);
    bus_write(2'd0, cfg);
    check("R5 sck_o idle level", sck_o, cfg[3]);
    exp_q.push_back(tx); tag_q.push_back("R3 R5 R6 master mosi byte");
    tog_n = 0;
    fork
      far_slave(stx, cfg[2], cfg[5]);
      bus_write(2'd2, tx);
      if (collide) begin repeat (40) @(negedge clk); bus_write(2'd2, 8'h5A); end
    join
    repeat (4) @(negedge clk);
    check("R4 SCK half-period", tog_t[1] - tog_t[0], half);
    check("R5 sck_o back at idle", sck_o, cfg[3]);
    clear_flags(collide ? 8'hC0 : 8'h80, stx);
  endtask

  task automatic slave_xfer(input logic [7:0] cfg, input logic [7:0] pre, input logic [7:0] mtx);
    logic [7:0] rx = '0;
    logic [7:0] v;
    bit cpha = cfg[2], lsb = cfg[5];
    sck_i = cfg[3];
    bus_write(2'd0, cfg);
    bus_write(2'd2, pre);
    check("R10 miso_oe low while deselected", miso_oe, 1'b0);
    exp_q.push_back(pre); tag_q.push_back("R10 slave miso byte");
    ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 miso_oe high while selected", miso_oe, 1'b1);
    for (int i = 0; i < 8; i++) begin
      if (!cpha) begin
        mosi_i = mtx[bp(i, lsb)];
        repeat (8) @(negedge clk);
        rx[bp(i, lsb)] = miso_o;
        sck_i = ~sck_i;
        repeat (8) @(negedge clk);
        sck_i = ~sck_i;
      end else begin
        sck_i = ~sck_i;
        mosi_i = mtx[bp(i, lsb)];
        repeat (8) @(negedge clk);
        rx[bp(i, lsb)] = miso_o;
        sck_i = ~sck_i;
        repeat (8) @(negedge clk);
      end
    end
    repeat (6) @(negedge clk);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    got_byte = rx;
    -> model_done;
    bus_read(2'd1, v);
    check("R11 slave completion flag", v, 8'h80);
    bus_read(2'd2, v);
    check("R10 slave received byte", v, mtx);
    bus_read(2'd1, v);
    check("R8 slave flags cleared", v, 8'h00);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
    glb_irq_en = 0; miso_i = 0; sck_i = 0; ss_n_i = 1; mosi_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(2'd0, v); check("R1 control reset value", v, 8'h04);
    bus_read(2'd1, v); check("R1 status reset value", v, 8'h00);
    check("R1 irq reset", irq, 1'b0);
    check("R1 sck_o reset", sck_o, 1'b0);
    check("R1 miso_oe reset", miso_oe, 1'b0);
    bus_write(2'd0, 8'h2B);
    bus_read(2'd0, v); check("R2 control readback", v, 8'h2B);

    // Master, all four clock modes, both orders, all rate codes
    master_xfer(8'h50, 8'hA5, 8'h3C, 2,  0);
    master_xfer(8'h75, 8'h81, 8'h7E, 8,  0);
    master_xfer(8'h5A, 8'hC3, 8'h19, 32, 0);
    master_xfer(8'h7F, 8'h96, 8'hE1, 64, 0);
    // Collision: write mid-transfer is dropped
    master_xfer(8'h51, 8'h0F, 8'hF0, 8,  1);

    // Interrupt gating R9
    bus_write(2'd0, 8'hD0);
    fork far_slave(8'h22, 1'b0, 1'b0); bus_write(2'd2, 8'h11); join
    exp_q.push_back(8'h11); tag_q.push_back("R9 run mosi byte");
    -> model_done;
    repeat (3) @(negedge clk);
    check("R9 irq low with global enable 0", irq, 1'b0);
    glb_irq_en = 1'b1; #1;
    check("R9 irq high with all enables", irq, 1'b1);
    bus_write(2'd0, 8'h50);
    check("R9 irq low with local enable 0", irq, 1'b0);
    bus_write(2'd0, 8'hD0);
    check("R9 irq back high", irq, 1'b1);
    bus_read(2'd1, v); bus_read(2'd2, v);
    check("R9 irq low after clear", irq, 1'b0);

    // Slave mode R10
    slave_xfer(8'h40, 8'h5C, 8'hA3);
    slave_xfer(8'h6F, 8'h72, 8'h8D);
    // Deselected: clock activity must not shift
    bus_write(2'd2, 8'h3E);
    for (int i = 0; i < 16; i++) begin
      sck_i = ~sck_i; mosi_i = ~mosi_i;
      repeat (6) @(negedge clk);
    end
    bus_read(2'd1, v); check("R10 no completion while deselected", v, 8'h00);
    bus_read(2'd2, v); check("R10 data unchanged while deselected", v, 8'h3E);
    check("R10 miso_oe low while deselected", miso_oe, 1'b0);

    repeat (5) @(negedge clk);
    summary();
  end
endmodule